// File: doc/BRIEF.md
# Aliased Display Control Register File

This block is the control and status register file that sits in front of a display controller's pixel engine. A simple 32-bit register bus reaches it. Each register can be written in three ways. A plain write replaces the whole register. A set write ORs a mask into it. A clear write removes a mask from it. Software can therefore change one control bit without a read-modify-write. A fourth alias is a read-only mirror.

The main control register carries four bits with their own behaviour:
- a soft-reset bit in the top bit,
- a clock-gate bit just below it,
- a run bit that starts the fetch engine,
- a dot-clock mode bit.

Releasing soft reset or the clock gate does not take effect at once. The bit keeps reading one for a fixed settle time, and bring-up software polls it. Stopping the engine is also deferred. The run bit keeps reading one until the pixel pipeline reports that it has drained, through the `drain_done` pulse. A second register holds a FIFO-flush control, and a third holds the sync-output enable. Any further registers are plain storage.

Top module: `ctl_alias_regs`

## Requirements
- R1: After reset the main control register (index 0) reads 0xC000_0000, with soft reset and clock gate both set. Every other register reads zero, and `run_o` is 0.
- R2: A plain write (address bits [1:0] = 0) replaces the whole addressed register. For register index 3 the readback equals the written word.
- R3: A set write (bits [1:0] = 1) ORs the data into the register. A clear write (bits [1:0] = 2) clears the bits that are one in the data. Bits outside the mask keep their value.
- R4: A write with bits [1:0] = 3 changes nothing. All four aliases of a register read its current value. Register indices at or above NUM_REGS read zero.
- R5: While soft reset (main bit 31) reads one, writes to every other bit of every register are ignored. Setting soft reset returns all other bits to their reset values in the same cycle.
- R6: After a write that clears soft reset, the bit reads one for SETTLE_CYC more clock edges, then reads zero. A clear write while the bit is already zero changes nothing.
- R7: The clock-gate bit (main bit 30) releases with the same SETTLE_CYC latency. A clear write to it while soft reset reads one is ignored.
- R8: The run bit (main bit 0) sets only if the sync-enable bit (register 2 bit 0) was already one before the write.
- R9: While running, a write that clears run or clears dot-clock mode (main bit 1) leaves run reading one. The dot-clock bit itself clears at once. Run reads zero on the clock edge where `drain_done` is sampled high.
- R10: A `drain_done` pulse while no stop is pending has no effect.
- R11: `fifo_flush_o` follows register 1 bit 0, and `sync_en_o` follows register 2 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address: [ADDR_W-1:2] register index, [1:0] alias |
| bus_wdata | input | DATA_W | Write data or mask |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| drain_done | input | 1 | One-cycle pulse: pixel pipeline has emptied |
| soft_reset_o | output | 1 | Soft-reset state |
| clk_gate_o | output | 1 | Clock-gate state |
| run_o | output | 1 | Fetch engine enable |
| dotclk_o | output | 1 | Dot-clock mode |
| sync_en_o | output | 1 | Sync outputs enable |
| fifo_flush_o | output | 1 | Pixel FIFO flush |

## Verification
Plain, set and clear writes are swept over a scratch register with walking and mixed masks. Each expected word is computed arithmetically, which shows that an alias touches only the bits of its mask. The bring-up order is replayed with a poll counter, so the settle latency of soft reset and clock gate is measured exactly. The second, redundant clear in that order is shown to return immediately. Run is started with sync enabled and with it disabled, and stopped both by a dot-clock clear and by a direct run clear. Stray drain pulses are injected to tell a pending stop apart from an idle one. A final soft reset asserted while running shows that every register and output falls back together.

// File: rtl/ctl_alias_pkg.sv
package ctl_alias_pkg;

   typedef enum logic [1:0] {
      ALIAS_PLAIN  = 2'd0,
      ALIAS_SET    = 2'd1,
      ALIAS_CLR    = 2'd2,
      ALIAS_MIRROR = 2'd3
   } alias_e;

   localparam int REG_MAIN  = 0;
   localparam int REG_AUX   = 1;
   localparam int REG_SYNC  = 2;

   localparam int RUN_BIT   = 0;
   localparam int DOT_BIT   = 1;
   localparam int FLUSH_BIT = 0;
   localparam int SYNC_BIT  = 0;

endpackage

// File: rtl/ctl_alias_merge.sv
module ctl_alias_merge
   import ctl_alias_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alias_e              kind_i,
   input  logic [DATA_W-1:0]   cur_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   nxt_o
);

   always_comb begin
      unique case (kind_i)
         ALIAS_PLAIN: nxt_o = wdata_i;
         ALIAS_SET:   nxt_o = cur_i | wdata_i;
         ALIAS_CLR:   nxt_o = cur_i & ~wdata_i;
         default:     nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/ctl_alias_settle.sv
module ctl_alias_settle #(
   parameter int SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_set,
   input  logic start_clr,
   output logic bit_o,
   output logic req_o,
   output logic pend_o
);

   localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

   logic          bit_q;
   logic          pend_q;
   logic [CW-1:0] cnt_q;

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("ctl_alias_settle: SETTLE_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q  <= 1'b1;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (force_set) begin
         bit_q  <= 1'b1;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (pend_q) begin
         if (cnt_q == '0) begin
            bit_q  <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else if (start_clr && bit_q) begin
         pend_q <= 1'b1;
         cnt_q  <= LOAD;
      end
   end

   assign bit_o  = bit_q;
   assign pend_o = pend_q;
   assign req_o  = bit_q & ~pend_q;

endmodule

// File: rtl/ctl_alias_drain.sv
module ctl_alias_drain (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic set_req,
   input  logic stop_req,
   input  logic drain_done,
   output logic run_o,
   output logic pend_o
);

   logic run_q;
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (flush) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (drain_done) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
         end
      end else if (run_q) begin
         if (stop_req) pend_q <= 1'b1;
      end else if (set_req) begin
         run_q <= 1'b1;
      end
   end

   assign run_o  = run_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/ctl_alias_regs.sv
module ctl_alias_regs
   import ctl_alias_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 5,
   parameter int NUM_REGS   = 4,
   parameter int SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              drain_done,
   output logic              soft_reset_o,
   output logic              clk_gate_o,
   output logic              run_o,
   output logic              dotclk_o,
   output logic              sync_en_o,
   output logic              fifo_flush_o
);

   localparam int IDX_W    = ADDR_W - 2;
   localparam int SRST_BIT = DATA_W - 1;
   localparam int GATE_BIT = DATA_W - 2;
   localparam logic [DATA_W-1:0] GEN_MASK =
      ~((DATA_W'(1) << SRST_BIT) | (DATA_W'(1) << GATE_BIT) | (DATA_W'(1) << RUN_BIT));

   if (DATA_W < 32) begin : g_bad_width
      $error("ctl_alias_regs: DATA_W must be at least 32");
   end
   if (NUM_REGS < 3) begin : g_bad_count
      $error("ctl_alias_regs: NUM_REGS must be at least 3");
   end
   if (ADDR_W < 3 || NUM_REGS > (1 << (ADDR_W - 2))) begin : g_bad_addr
      $error("ctl_alias_regs: ADDR_W too small for NUM_REGS");
   end

   logic [IDX_W-1:0] idx;
   alias_e           kind;
   assign idx  = bus_addr[ADDR_W-1:2];
   assign kind = alias_e'(bus_addr[1:0]);

   logic [DATA_W-1:0]                 reg_q   [NUM_REGS];
   logic [DATA_W-1:0]                 rd_view [NUM_REGS];
   logic [DATA_W-1:0]                 mrg_cur [NUM_REGS];
   logic [NUM_REGS-1:0][DATA_W-1:0]   nxt_all;
   logic [NUM_REGS-1:0]               hit;

   logic srst_q, srst_req, srst_pend;
   logic gate_q, gate_req, gate_pend;
   logic run_q, drain_pend;

   // Per-register alias decode and merge
   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      assign hit[gi] = bus_wr && (kind != ALIAS_MIRROR) && (idx == IDX_W'(gi));

      ctl_alias_merge #(.DATA_W(DATA_W)) u_merge (
         .kind_i  (kind),
         .cur_i   (mrg_cur[gi]),
         .wdata_i (bus_wdata),
         .nxt_o   (nxt_all[gi])
      );
   end

   logic [DATA_W-1:0] main_nxt;
   logic              main_hit;
   assign main_nxt = nxt_all[REG_MAIN];
   assign main_hit = hit[REG_MAIN];

   // Soft reset: set at once, release after settle
   logic srst_set, srst_clr, held;
   assign srst_set = main_hit &&  main_nxt[SRST_BIT];
   assign srst_clr = main_hit && !main_nxt[SRST_BIT];
   assign held     = srst_q || srst_set;

   ctl_alias_settle #(.SETTLE_CYC(SETTLE_CYC)) u_srst (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_set (srst_set),
      .start_clr (srst_clr),
      .bit_o     (srst_q),
      .req_o     (srst_req),
      .pend_o    (srst_pend)
   );

   // Clock gate: forced while soft reset holds, release after settle
   logic gate_set, gate_clr;
   assign gate_set = held || (main_hit && main_nxt[GATE_BIT]);
   assign gate_clr = main_hit && !main_nxt[GATE_BIT] && !held;

   ctl_alias_settle #(.SETTLE_CYC(SETTLE_CYC)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_set (gate_set),
      .start_clr (gate_clr),
      .bit_o     (gate_q),
      .req_o     (gate_req),
      .pend_o    (gate_pend)
   );

   // Run bit with deferred stop
   logic sync_q, run_set, run_stop;
   assign sync_q   = reg_q[REG_SYNC][SYNC_BIT];
   assign run_set  = main_hit && !held && main_nxt[RUN_BIT] && sync_q;
   assign run_stop = main_hit && !held && (!main_nxt[RUN_BIT] || !main_nxt[DOT_BIT]);

   ctl_alias_drain u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (held),
      .set_req    (run_set),
      .stop_req   (run_stop),
      .drain_done (drain_done),
      .run_o      (run_q),
      .pend_o     (drain_pend)
   );

   // Stored bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (held) begin
               reg_q[i] <= '0;
            end else if (hit[i]) begin
               if (i == REG_MAIN) reg_q[i] <= nxt_all[i] & GEN_MASK;
               else               reg_q[i] <= nxt_all[i];
            end
         end
      end
   end

   // Read view and merge base (pending releases merge as already cleared)
   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) begin
         rd_view[i] = reg_q[i];
         mrg_cur[i] = reg_q[i];
      end
      rd_view[REG_MAIN][SRST_BIT] = srst_q;
      rd_view[REG_MAIN][GATE_BIT] = gate_q;
      rd_view[REG_MAIN][RUN_BIT]  = run_q;
      mrg_cur[REG_MAIN][SRST_BIT] = srst_req;
      mrg_cur[REG_MAIN][GATE_BIT] = gate_req;
      mrg_cur[REG_MAIN][RUN_BIT]  = run_q;
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == IDX_W'(i)) bus_rdata = rd_view[i];
      end
   end

   assign soft_reset_o = srst_q;
   assign clk_gate_o   = gate_q;
   assign run_o        = run_q;
   assign dotclk_o     = reg_q[REG_MAIN][DOT_BIT];
   assign sync_en_o    = sync_q;
   assign fifo_flush_o = reg_q[REG_AUX][FLUSH_BIT];

endmodule

// File: rtl/ctl_alias_regs_chk.sv
module ctl_alias_regs_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_reset_o,
   input logic clk_gate_o,
   input logic run_o,
   input logic sync_en_o,
   input logic fifo_flush_o,
   input logic drain_done,
   input logic srst_pend,
   input logic gate_pend,
   input logic drain_pend
);

   // R5
   hold_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset_o |-> (!run_o && clk_gate_o && !sync_en_o && !fifo_flush_o));

   // R6
   srst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(soft_reset_o) |-> $past(srst_pend));

   // R7
   gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_gate_o) |-> ($past(gate_pend) && !soft_reset_o));

   // R8
   run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> $past(sync_en_o));

   // R9
   run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_o) |-> (($past(drain_done) && $past(drain_pend)) || soft_reset_o));

endmodule

bind ctl_alias_regs ctl_alias_regs_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .soft_reset_o (soft_reset_o),
   .clk_gate_o   (clk_gate_o),
   .run_o        (run_o),
   .sync_en_o    (sync_en_o),
   .fifo_flush_o (fifo_flush_o),
   .drain_done   (drain_done),
   .srst_pend    (srst_pend),
   .gate_pend    (gate_pend),
   .drain_pend   (drain_pend)
);

// File: tb/ctl_alias_regs_test.sv
module ctl_alias_regs_test;

   localparam int DW = 32;
   localparam int AW = 5;
   localparam int NR = 4;
   localparam int ST = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          drain_done = 1'b0;
   logic          soft_reset_o, clk_gate_o, run_o, dotclk_o, sync_en_o, fifo_flush_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   ctl_alias_regs #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR), .SETTLE_CYC(ST)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drain_done(drain_done),
      .soft_reset_o(soft_reset_o), .clk_gate_o(clk_gate_o), .run_o(run_o),
      .dotclk_o(dotclk_o), .sync_en_o(sync_en_o), .fifo_flush_o(fifo_flush_o)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input int al, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = AW'(idx * 4 + al);
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int idx, input int al, output logic [DW-1:0] v);
      bus_addr = AW'(idx * 4 + al);
      #1 v = bus_rdata;
   endtask

   task automatic drain_pulse();
      @(negedge clk);
      drain_done = 1'b1;
      @(negedge clk);
      drain_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v, model, m;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, 0, v); chk("R1 main", v, 32'hC000_0000);
      for (int i = 1; i < NR; i++) begin
         rd(i, 0, v); chk("R1 other", v, 0);
      end
      chk("R1 run", DW'(run_o), 0);

      // R5 writes ignored under soft reset; R7 gate clear ignored too
      wr(3, 0, 32'hFFFF_0000);
      rd(3, 0, v); chk("R5 scratch held", v, 0);
      wr(2, 1, 32'h1);
      chk("R5 sync held", DW'(sync_en_o), 0);
      wr(0, 2, 32'h4000_0000);
      repeat (2 * ST) @(negedge clk);
      chk("R7 gate held in reset", DW'(clk_gate_o), 1);

      // R6 bring-up: release soft reset, poll
      wr(0, 2, 32'h8000_0000);
      n = 0;
      while (soft_reset_o && n < 20) begin @(negedge clk); n++; end
      chk("R6 srst settle", DW'(n), DW'(ST));
      // R7 release gate, poll
      wr(0, 2, 32'h4000_0000);
      n = 0;
      while (clk_gate_o && n < 20) begin @(negedge clk); n++; end
      chk("R7 gate settle", DW'(n), DW'(ST));
      // repeated clears return immediately
      wr(0, 2, 32'h8000_0000);
      chk("R6 second clear", DW'(soft_reset_o), 0);
      wr(0, 2, 32'h4000_0000);
      chk("R7 second clear", DW'(clk_gate_o), 0);
      rd(0, 0, v); chk("R6 main after bring-up", v, 0);

      // R2 plain write sweep
      for (int i = 0; i < 16; i++) begin
         m = (32'h1 << (2 * i)) ^ (32'h0101_0101 * i) ^ 32'hA5A5_0000;
         wr(3, 0, m);
         rd(3, 0, v); chk("R2 plain", v, m);
      end

      // R3 set/clear sweep with arithmetic model
      wr(3, 0, 32'h0000_FFFF);
      model = 32'h0000_FFFF;
      for (int i = 0; i < 12; i++) begin
         m = 32'h0003_0000 << i;
         wr(3, 1, m); model = model | m;
         rd(3, 0, v); chk("R3 set", v, model);
         m = 32'h0000_0101 << i;
         wr(3, 2, m); model = model & ~m;
         rd(3, 0, v); chk("R3 clear", v, model);
      end
      wr(0, 1, 32'h00F0_0000);
      rd(0, 0, v); chk("R3 main set", v, 32'h00F0_0000);
      wr(0, 2, 32'h0030_0000);
      rd(0, 0, v); chk("R3 main clear", v, 32'h00C0_0000);

      // R4 aliases and mirror
      for (int a = 1; a < 4; a++) begin
         rd(3, a, v); chk("R4 alias read", v, model);
      end
      wr(3, 3, 32'h1234_5678);
      rd(3, 0, v); chk("R4 mirror write ignored", v, model);
      for (int i = NR; i < 8; i++) begin
         rd(i, 0, v); chk("R4 unmapped", v, 0);
      end

      // R8 run needs sync enable
      wr(0, 1, 32'h3);
      chk("R8 run blocked", DW'(run_o), 0);
      rd(0, 0, v); chk("R8 main bit0", v & 32'h1, 0);
      wr(2, 1, 32'h1);
      chk("R11 sync out", DW'(sync_en_o), 1);
      wr(0, 1, 32'h1);
      chk("R8 run set", DW'(run_o), 1);

      // R10 stray drain pulse
      drain_pulse();
      chk("R10 stray drain", DW'(run_o), 1);

      // R9 stop via dot-clock clear
      wr(0, 2, 32'h2);
      chk("R9 dot clears", DW'(dotclk_o), 0);
      repeat (5) @(negedge clk);
      chk("R9 run holds", DW'(run_o), 1);
      rd(0, 0, v); chk("R9 run reads one", v & 32'h1, 1);
      drain_pulse();
      chk("R9 run after drain", DW'(run_o), 0);

      // R9 stop via run clear
      wr(0, 1, 32'h3);
      chk("R9 restart", DW'(run_o), 1);
      wr(0, 2, 32'h1);
      repeat (3) @(negedge clk);
      chk("R9 run clear deferred", DW'(run_o), 1);
      drain_pulse();
      chk("R9 run clear done", DW'(run_o), 0);
      drain_pulse();
      chk("R10 idle drain", DW'(run_o), 0);

      // R11 flush control
      wr(1, 1, 32'h1);
      chk("R11 flush on", DW'(fifo_flush_o), 1);
      wr(1, 2, 32'h1);
      chk("R11 flush off", DW'(fifo_flush_o), 0);

      // R5 soft reset while running
      wr(1, 1, 32'h1);
      wr(0, 1, 32'h3);
      chk("R5 running again", DW'(run_o), 1);
      wr(0, 1, 32'h8000_0000);
      chk("R5 run dropped", DW'(run_o), 0);
      chk("R5 gate set", DW'(clk_gate_o), 1);
      chk("R5 flush dropped", DW'(fifo_flush_o), 0);
      chk("R5 sync dropped", DW'(sync_en_o), 0);
      rd(0, 0, v); chk("R5 main", v, 32'hC000_0000);
      rd(3, 0, v); chk("R5 scratch", v, 0);

      finish_run();
   end

endmodule